// File: doc/BRIEF.md
# Hamming check-bit encoder

This block produces the check bits of a Hamming code for a message whose width is set by a parameter. The message is not merged into a codeword. It leaves on its own output port, registered and unchanged, and the check bits leave on a separate port in the same cycle. A downstream decoder receives both ports and can correct or detect errors that occur between the two blocks.

The number of check bits is worked out from the message width when the design is elaborated. Two options change the code. The first adds one overall parity bit on top of the Hamming bits, so the decoder can tell a double error apart from a single one. The second drops the Hamming structure and keeps a single parity bit over the whole message. Both outputs are registered. A clock enable decides when new values are taken in, and an active-low asynchronous reset clears the outputs.

Top module: `hamming_parity_enc`

## Requirements
- R1: With the single-bit option off, the Hamming check-bit count R is the smallest r for which 2^r >= MSG_W + r + 1. parity_o is R + EXTRA_PAR bits wide. For MSG_W=11 that gives R=4.
- R2: Data bit j is assigned a 1-based codeword position. Positions count upward from 1 and skip every power of two, so bit 0 sits at position 3, bit 1 at 5, bit 2 at 6, bit 3 at 7 and bit 4 at 9. Check bit i is parity_o[i], and it is the XOR of every data bit whose position has bit i set.
- R3: data_o carries the value that data_i had at the capturing clock edge, with no change to any bit.
- R4: When en_i is high at a rising clock edge, data_o and parity_o show values derived from that edge's data_i immediately after the edge. The latency is one cycle.
- R5: When en_i is low at a rising clock edge, data_o and parity_o keep their previous values, whatever data_i is.
- R6: While rst_ni is low, data_o and parity_o are zero. The reset takes effect at once and does not wait for a clock edge.
- R7: When EXTRA_PAR=1, parity_o[R] is the XOR of all data bits and all R check bits. The XOR of every bit of data_o and parity_o is then always zero.
- R8: When SINGLE_PAR=1, R is 1 and parity_o[0] is the XOR of all data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Capture enable |
| data_i | input | MSG_W | Message in |
| data_o | output | MSG_W | Registered message out |
| parity_o | output | R + EXTRA_PAR | Registered check bits; the overall bit is the MSB when enabled |

## Verification
Several properties are checked by the assertions on every cycle:
- the hold when the enable is low;
- the one-cycle capture of data and parity;
- the zero state during reset;
- the even total parity of the outputs when the overall bit is enabled;
- the single-bit parity relation.

The bench's scenarios cover the rest:
- the position mapping of each check bit, using walking-one messages and mixed patterns compared against an independently computed code;
- the derived port width;
- the reset taking effect between clock edges.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

  // smallest r with 2^r >= msg_w + r + 1, or 1 in single-parity mode
  function automatic int check_count(int msg_w, bit single);
    int r;
    if (single) return 1;
    r = 1;
    while ((1 << r) < msg_w + r + 1) r++;
    return r;
  endfunction

  // 1-based codeword position of data bit idx (powers of two skipped)
  function automatic int data_pos(int idx);
    int seen;
    seen = 0;
    for (int p = 3; p < 65536; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == idx) return p;
        seen++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/hpe_check_gen.sv
module hpe_check_gen #(
  parameter int MSG_W      = 30,
  parameter bit SINGLE_PAR = 1'b0,
  parameter int CHK_W      = hpe_pkg::check_count(MSG_W, SINGLE_PAR)
) (
  input  logic [MSG_W-1:0] data_i,
  output logic [CHK_W-1:0] chk_o
);

  if (SINGLE_PAR) begin : g_single
    assign chk_o = ^data_i;
  end else begin : g_hamming
    for (genvar i = 0; i < CHK_W; i++) begin : g_bit
      logic [MSG_W-1:0] sel;
      for (genvar j = 0; j < MSG_W; j++) begin : g_sel
        localparam int POS = hpe_pkg::data_pos(j);
        assign sel[j] = POS[i];
      end
      assign chk_o[i] = ^(data_i & sel);
    end
  end

  always_comb begin
    if (data_i == '0)
      a_r2_zero_msg : assert (chk_o == '0);
  end

endmodule

// File: rtl/hpe_overall.sv
module hpe_overall #(
  parameter int MSG_W = 30,
  parameter int CHK_W = 6
) (
  input  logic [MSG_W-1:0] data_i,
  input  logic [CHK_W-1:0] chk_i,
  output logic             ovl_o
);

  assign ovl_o = (^data_i) ^ (^chk_i);

endmodule

// File: rtl/hpe_out_reg.sv
module hpe_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  a_r5_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

  a_r4_capture : assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o == $past(d_i));

  a_r6_reset_zero : assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);

endmodule

// File: rtl/hamming_parity_enc.sv
module hamming_parity_enc #(
  parameter int MSG_W      = 30,
  parameter int EXTRA_PAR  = 0,
  parameter bit SINGLE_PAR = 1'b0,
  localparam int CHK_W     = hpe_pkg::check_count(MSG_W, SINGLE_PAR),
  localparam int PAR_W     = CHK_W + EXTRA_PAR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [MSG_W-1:0] data_i,
  output logic [MSG_W-1:0] data_o,
  output logic [PAR_W-1:0] parity_o
);

  logic [CHK_W-1:0] chk;
  logic [PAR_W-1:0] par_nxt;

  hpe_check_gen #(
    .MSG_W      (MSG_W),
    .SINGLE_PAR (SINGLE_PAR),
    .CHK_W      (CHK_W)
  ) u_chk (
    .data_i (data_i),
    .chk_o  (chk)
  );

  if (EXTRA_PAR != 0) begin : g_extra
    logic ovl;
    hpe_overall #(
      .MSG_W (MSG_W),
      .CHK_W (CHK_W)
    ) u_ovl (
      .data_i (data_i),
      .chk_i  (chk),
      .ovl_o  (ovl)
    );
    assign par_nxt = {ovl, chk};

    a_r7_even_total : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (^{data_o, parity_o}) == 1'b0);
  end else begin : g_plain
    assign par_nxt = chk;
  end

  if (SINGLE_PAR) begin : g_single_chk
    a_r8_single_parity : assert property (@(posedge clk_i) disable iff (!rst_ni)
      parity_o[0] == ^data_o);
  end

  hpe_out_reg #(.DW(MSG_W)) u_data_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (data_i),
    .q_o    (data_o)
  );

  hpe_out_reg #(.DW(PAR_W)) u_par_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (par_nxt),
    .q_o    (parity_o)
  );

  a_r3_data_pass : assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> data_o == $past(data_i));

endmodule

// File: tb/hamming_parity_enc_test.sv
module hamming_parity_enc_test;

  localparam int PERIOD = 10;
  localparam int M   = 11;
  localparam int R   = 4;
  localparam int PW  = R + 1;
  localparam int M2  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic en = 1'b0;
  logic [M-1:0]  din = '0;
  logic [M-1:0]  dout;
  logic [PW-1:0] pout;
  logic [M2-1:0] din2 = '0;
  logic [M2-1:0] dout2;
  logic [0:0]    pout2;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  hamming_parity_enc #(.MSG_W(M), .EXTRA_PAR(1), .SINGLE_PAR(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .data_i(din), .data_o(dout), .parity_o(pout));

  hamming_parity_enc #(.MSG_W(M2), .EXTRA_PAR(0), .SINGLE_PAR(1'b1)) uut_single (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .data_i(din2), .data_o(dout2), .parity_o(pout2));

  function automatic logic [PW-1:0] ref_par(input logic [M-1:0] d);
    logic [R-1:0] c;
    int pos;
    c = '0;
    pos = 2;
    for (int j = 0; j < M; j++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      for (int i = 0; i < R; i++)
        if (((pos >> i) & 1) != 0) c[i] = c[i] ^ d[j];
    end
    return {(^d) ^ (^c), c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [M-1:0] d, input logic e);
    @(negedge clk);
    din = d;
    din2 = d[M2-1:0];
    en = e;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #2 rst_ni = 1'b0;
    #1;
    check("R6 data at reset", 32'(dout), 0);
    check("R6 parity at reset", 32'(pout), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_width;
    check("R1 parity width", $bits(uut.parity_o), PW);
    check("R8 single width", $bits(uut_single.parity_o), 1);
  endtask

  task automatic t_walking;
    for (int j = 0; j < M; j++) begin
      logic [M-1:0] d;
      d = '0;
      d[j] = 1'b1;
      drive(d, 1'b1);
      check("R2 walking one parity", 32'(pout), 32'(ref_par(d)));
      check("R3 walking one data", 32'(dout), 32'(d));
    end
    drive(11'h001, 1'b1);
    check("R2 bit0 pos3 -> chk 0,1", 32'(pout[R-1:0]), 32'h3);
    drive(11'h010, 1'b1);
    check("R2 bit4 pos9 -> chk 0,3", 32'(pout[R-1:0]), 32'h9);
  endtask

  task automatic t_patterns;
    logic [M-1:0] pats [6] = '{11'h7FF, 11'h555, 11'h2AA, 11'h0F0, 11'h123, 11'h000};
    foreach (pats[k]) begin
      drive(pats[k], 1'b1);
      check("R2 pattern parity", 32'(pout), 32'(ref_par(pats[k])));
      check("R7 overall bit", 32'(pout[R]), 32'((^pats[k]) ^ (^ref_par(pats[k])[R-1:0])));
      check("R8 single parity", 32'(pout2), 32'(^pats[k][M2-1:0]));
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    din = 11'h3C5;
    din2 = 8'hC5;
    en = 1'b1;
    @(posedge clk);
    #1;
    check("R4 one cycle data", 32'(dout), 32'h3C5);
    check("R4 one cycle parity", 32'(pout), 32'(ref_par(11'h3C5)));
  endtask

  task automatic t_hold;
    logic [M-1:0] keep_d;
    logic [PW-1:0] keep_p;
    drive(11'h4B1, 1'b1);
    keep_d = dout;
    keep_p = pout;
    drive(11'h2CE, 1'b0);
    drive(11'h7FF, 1'b0);
    check("R5 hold data", 32'(dout), 32'(keep_d));
    check("R5 hold parity", 32'(pout), 32'(keep_p));
    drive(11'h2CE, 1'b1);
    check("R5 resume after hold", 32'(dout), 32'h2CE);
  endtask

  task automatic t_async_reset;
    drive(11'h6DB, 1'b1);
    @(posedge clk);
    #2 rst_ni = 1'b0;
    #1;
    check("R6 async data", 32'(dout), 0);
    check("R6 async parity", 32'(pout), 0);
    check("R6 async single", 32'(pout2), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_width;
    t_walking;
    t_patterns;
    t_latency;
    t_hold;
    t_async_reset;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule